// File: doc/BRIEF.md
# Virtual Interrupt Priority Register Bank

This block is a hypervisor-level register bank. It holds one control register for virtual interrupts and a store of 64 eight-bit priorities for those interrupts. Software reaches both through a single-cycle CSR port made of an address, read and write enables, write data, a width select (32- or 64-bit register width), a virtualization flag and a feature-enable input. Each priority CSR packs several priority bytes. At 64-bit width there are eight per access and at 32-bit width there are four. A fixed index map sends each byte lane to an interrupt number. In that map some slots are hardwired to read zero and some have no interrupt behind them.

The block reports a fault code for each access. It also drives a gate towards the neighbouring supervisor CSR logic. That logic uses the gate to turn guest accesses to the interrupt-enable and interrupt-pending registers into virtual-instruction faults. Interrupt selection and delivery are handled elsewhere.

Top module: `virq_prio_bank`

## Requirements
- R1: After reset, every priority byte reads as 0, the control register reads as 0 and the guest gate is low.
- R2: At 32-bit width one access covers 4 priority bytes and bits 63:32 of the read data are 0. At 64-bit width one access covers 8 bytes. Byte lane i sits at bits 8i+7:8i and serves index start+i.
- R3: The priority CSR addresses map to these starting indices: 0x646 to index 0, 0x656 to index 4, 0x647 to index 8 and 0x657 to index 12. The control register sits at 0x609.
- R4: When a priority CSR's starting index is not a multiple of the lane count, the access faults. The code is 2 (virtual instruction) when virt_i is high and 1 (illegal instruction) otherwise. No state changes on a faulting access. For this reason the 0x656 and 0x657 registers work only at 32-bit width.
- R5: Index 0 is a read-zero slot. It always reads 0, and a write through it clears its stored priority (interrupt 12) whatever the write data.
- R6: Indices 2, 4 and 6 are unmapped. They read 0 and ignore writes. Every other index below 16 maps to interrupt index+12.
- R7: A control write keeps only the bits in mask 0x40FF033F. A read returns the stored value. A write at 32-bit width leaves bits 63:32 as they were, and a read at 32-bit width shows only bits 31:0.
- R8: The guest gate output is high exactly when control bit 30 is set and virt_i is high.
- R9: When feat_en_i is low, any read or write to the five bank addresses returns fault code 1 and changes nothing.
- R10: Reads are combinational from the stored state. A write takes effect at the next clock edge.
- R11: An access to any other address returns fault code 0 and read data 0 and changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| csr_addr_i | input | 12 | CSR address |
| csr_re_i | input | 1 | Read enable |
| csr_we_i | input | 1 | Write enable |
| csr_wdata_i | input | 64 | Write data |
| xlen64_i | input | 1 | 1 for 64-bit register width, 0 for 32-bit |
| virt_i | input | 1 | Hart runs in virtualized mode |
| feat_en_i | input | 1 | Feature enable for this bank |
| csr_rdata_o | output | 64 | Read data |
| fault_o | output | 2 | 0 none, 1 illegal instruction, 2 virtual instruction |
| guest_ie_ip_trap_o | output | 1 | Tells supervisor CSR logic to fault guest enable/pending accesses |

## Verification
The assertions check several properties on every cycle. The fault code never takes its unused value. A bank access with the feature disabled leaves the control register unchanged. The control register never holds bits outside the mask. The upper read half stays zero at 32-bit width. A read-zero write leaves a zero priority. The gate stays low outside virtualized mode. Lane-to-index packing, the unmapped and read-zero slots, and the virt-dependent misalignment fault that separates the two width modes are different: only the bench's scenarios can show them, by comparing read data and fault codes with a behavioural model across fixed and pseudo-random accesses.

// File: rtl/virq_prio_pkg.sv
package virq_prio_pkg;
  localparam int unsigned NUM_PRIO = 64;
  localparam int unsigned PRIO_W   = 8;
  localparam int unsigned IRQ_W    = $clog2(NUM_PRIO);
  localparam int unsigned XLEN_MAX = 64;
  localparam int unsigned LANES    = XLEN_MAX / PRIO_W;
  localparam int unsigned START_W  = 5;

  typedef enum logic [1:0] {
    FLT_NONE    = 2'd0,
    FLT_ILLEGAL = 2'd1,
    FLT_VIRT    = 2'd2
  } fault_e;

  typedef struct packed {
    logic             map;
    logic             rdz;
    logic [IRQ_W-1:0] irq;
  } lane_t;
endpackage

// File: rtl/virq_idx_map.sv
module virq_idx_map
  import virq_prio_pkg::*;
#(
  parameter int unsigned  NUM_IDX    = 16,
  parameter logic [15:0]  IDX_VALID  = 16'hFFAB,
  parameter logic [15:0]  IDX_RDZERO = 16'h0001,
  parameter int unsigned  IRQ_BASE   = 12
) (
  input  logic [START_W-1:0]   start_i,
  input  logic                 xlen64_i,
  output lane_t [LANES-1:0]    lanes_o
);
  localparam int unsigned IDX_W = $clog2(NUM_IDX);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [START_W:0] idx;
    logic             act;
    logic             in_rng;
    assign idx    = {1'b0, start_i} + (START_W+1)'(g);
    assign act    = (g < LANES/2) || xlen64_i;
    assign in_rng = idx < (START_W+1)'(NUM_IDX);
    assign lanes_o[g].map = act && in_rng && IDX_VALID[idx[IDX_W-1:0]];
    assign lanes_o[g].rdz = IDX_RDZERO[idx[IDX_W-1:0]];
    assign lanes_o[g].irq = IRQ_W'(idx) + IRQ_W'(IRQ_BASE);
  end
endmodule

// File: rtl/virq_prio_store.sv
module virq_prio_store
  import virq_prio_pkg::*;
(
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      we_i,
  input  lane_t [LANES-1:0]         lanes_i,
  input  logic [LANES*PRIO_W-1:0]   wdata_i,
  output logic [LANES*PRIO_W-1:0]   rdata_o
);
  logic [PRIO_W-1:0] mem_q [NUM_PRIO];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < NUM_PRIO; k++) mem_q[k] <= '0;
    end else if (we_i) begin
      for (int k = 0; k < NUM_PRIO; k++) begin
        for (int l = 0; l < LANES; l++) begin
          if (lanes_i[l].map && lanes_i[l].irq == IRQ_W'(k))
            mem_q[k] <= lanes_i[l].rdz ? '0 : wdata_i[l*PRIO_W +: PRIO_W];
        end
      end
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_rd
    assign rdata_o[g*PRIO_W +: PRIO_W] =
      (lanes_i[g].map && !lanes_i[g].rdz) ? mem_q[lanes_i[g].irq] : '0;

    // read-zero write leaves a cleared entry
    assert_rdz_clear_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (we_i && lanes_i[g].map && lanes_i[g].rdz) |=> mem_q[$past(lanes_i[g].irq)] == '0);
  end
endmodule

// File: rtl/virq_ctl_reg.sv
module virq_ctl_reg
  import virq_prio_pkg::*;
#(
  parameter logic [XLEN_MAX-1:0] CTL_MASK = 64'h0000_0000_40FF_033F
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 we_i,
  input  logic                 xlen64_i,
  input  logic [XLEN_MAX-1:0]  wdata_i,
  output logic [XLEN_MAX-1:0]  ctl_o,
  output logic [XLEN_MAX-1:0]  rdata_o
);
  localparam int unsigned HALF = XLEN_MAX / 2;
  logic [XLEN_MAX-1:0] ctl_q, ctl_d;

  assign ctl_d = (xlen64_i ? wdata_i : {ctl_q[XLEN_MAX-1:HALF], wdata_i[HALF-1:0]}) & CTL_MASK;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   ctl_q <= '0;
    else if (we_i) ctl_q <= ctl_d;
  end

  assign ctl_o   = ctl_q;
  assign rdata_o = xlen64_i ? ctl_q : {{HALF{1'b0}}, ctl_q[HALF-1:0]};

  assert_ctl_masked_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_q & ~CTL_MASK) == '0);
endmodule

// File: rtl/virq_prio_bank.sv
module virq_prio_bank
  import virq_prio_pkg::*;
#(
  parameter logic [11:0]          ADDR_CTL  = 12'h609,
  parameter logic [11:0]          ADDR_PA   = 12'h646,
  parameter logic [11:0]          ADDR_PAH  = 12'h656,
  parameter logic [11:0]          ADDR_PB   = 12'h647,
  parameter logic [11:0]          ADDR_PBH  = 12'h657,
  parameter logic [XLEN_MAX-1:0]  CTL_MASK  = 64'h0000_0000_40FF_033F,
  parameter int unsigned          GATE_BIT  = 30
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [11:0]          csr_addr_i,
  input  logic                 csr_re_i,
  input  logic                 csr_we_i,
  input  logic [XLEN_MAX-1:0]  csr_wdata_i,
  input  logic                 xlen64_i,
  input  logic                 virt_i,
  input  logic                 feat_en_i,
  output logic [XLEN_MAX-1:0]  csr_rdata_o,
  output logic [1:0]           fault_o,
  output logic                 guest_ie_ip_trap_o
);
  logic               hit_ctl, hit_prio, aligned, acc, ok;
  logic [START_W-1:0] start;
  fault_e             fault;
  lane_t [LANES-1:0]  lanes;
  logic [XLEN_MAX-1:0] prio_rdata, ctl_rdata, ctl_q;

  assign hit_ctl = csr_addr_i == ADDR_CTL;

  always_comb begin
    hit_prio = 1'b1;
    start    = '0;
    unique case (csr_addr_i)
      ADDR_PA:  start = START_W'(0);
      ADDR_PAH: start = START_W'(4);
      ADDR_PB:  start = START_W'(8);
      ADDR_PBH: start = START_W'(12);
      default:  hit_prio = 1'b0;
    endcase
  end

  assign aligned = xlen64_i ? (start[2:0] == '0) : (start[1:0] == '0);
  assign acc     = csr_re_i || csr_we_i;
  assign ok      = feat_en_i && (hit_ctl || (hit_prio && aligned));

  always_comb begin
    fault = FLT_NONE;
    if (acc && (hit_ctl || hit_prio)) begin
      if (!feat_en_i)                fault = FLT_ILLEGAL;
      else if (hit_prio && !aligned) fault = virt_i ? FLT_VIRT : FLT_ILLEGAL;
    end
  end
  assign fault_o = fault;

  virq_idx_map u_map (
    .start_i  (start),
    .xlen64_i (xlen64_i),
    .lanes_o  (lanes)
  );

  virq_prio_store u_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (csr_we_i && ok && hit_prio),
    .lanes_i (lanes),
    .wdata_i (csr_wdata_i),
    .rdata_o (prio_rdata)
  );

  virq_ctl_reg #(.CTL_MASK(CTL_MASK)) u_ctl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (csr_we_i && ok && hit_ctl),
    .xlen64_i (xlen64_i),
    .wdata_i  (csr_wdata_i),
    .ctl_o    (ctl_q),
    .rdata_o  (ctl_rdata)
  );

  always_comb begin
    csr_rdata_o = '0;
    if (ok && hit_prio)     csr_rdata_o = prio_rdata;
    else if (ok && hit_ctl) csr_rdata_o = ctl_rdata;
  end

  assign guest_ie_ip_trap_o = ctl_q[GATE_BIT] && virt_i;

  assert_fault_code_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o != 2'd3);
  assert_feat_off_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csr_we_i && !feat_en_i) |=> $stable(ctl_q));
  assert_upper_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !xlen64_i |-> csr_rdata_o[XLEN_MAX-1:XLEN_MAX/2] == '0);
  assert_gate_host_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !virt_i |-> !guest_ie_ip_trap_o);
  assert_other_addr_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hit_ctl && !hit_prio) |-> (fault_o == 2'd0 && csr_rdata_o == '0));
endmodule

// File: tb/virq_prio_bank_bench.sv
`timescale 1ns/1ps
module virq_prio_bank_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] addr = '0;
  logic        re = 1'b0, we = 1'b0;
  logic [63:0] wd = '0;
  logic        x64 = 1'b1, virt = 1'b0, feat = 1'b1;
  logic [63:0] rdata;
  logic [1:0]  fault;
  logic        gate;

  int checks = 0, fails = 0;
  bit done = 0;

  byte unsigned prio_m [64];
  logic [63:0]  ctl_m;
  localparam logic [63:0] MASK = 64'h0000_0000_40FF_033F;

  always #2 clk = ~clk;

  virq_prio_bank u_virq_prio_bank (
    .clk_i(clk), .rst_ni(rst_n), .csr_addr_i(addr), .csr_re_i(re), .csr_we_i(we),
    .csr_wdata_i(wd), .xlen64_i(x64), .virt_i(virt), .feat_en_i(feat),
    .csr_rdata_o(rdata), .fault_o(fault), .guest_ie_ip_trap_o(gate)
  );

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int start_of(logic [11:0] a);
    case (a)
      12'h646: return 0;
      12'h656: return 4;
      12'h647: return 8;
      12'h657: return 12;
      default: return -1;
    endcase
  endfunction

  function automatic bit mapped(int idx);
    return idx < 16 && idx != 2 && idx != 4 && idx != 6;
  endfunction

  task automatic access(logic [11:0] a, bit r, bit w, logic [63:0] d,
                        bit wide, bit v, bit f, string tag);
    int st, nl;
    bit okay;
    logic [1:0]  ef;
    logic [63:0] er;
    @(negedge clk);
    addr = a; re = r; we = w; wd = d; x64 = wide; virt = v; feat = f;
    st = start_of(a);
    nl = wide ? 8 : 4;
    ef = 2'd0; er = '0; okay = 0;
    if (a == 12'h609 || st >= 0) begin
      if (!f)                  ef = 2'd1;
      else if (st >= 0 && (st % nl) != 0) ef = v ? 2'd2 : 2'd1;
      else                     okay = 1;
      if (!(r || w)) ef = 2'd0;
    end
    if (okay && st >= 0) begin
      for (int i = 0; i < nl; i++)
        if (mapped(st + i) && st + i != 0) er[8*i +: 8] = prio_m[st + i + 12];
    end else if (okay) begin
      er = wide ? ctl_m : {32'b0, ctl_m[31:0]};
    end
    #1;
    chk({tag, " fault"}, {62'b0, fault}, {62'b0, ef});
    if (r) chk({tag, " rdata"}, rdata, er);
    chk({tag, " R8 gate"}, {63'b0, gate}, {63'b0, ctl_m[30] & v});
    @(posedge clk);
    if (w && okay) begin
      if (st >= 0) begin
        for (int i = 0; i < nl; i++)
          if (mapped(st + i)) prio_m[st + i + 12] = (st + i == 0) ? 8'h00 : d[8*i +: 8];
      end else begin
        ctl_m = (wide ? d : {ctl_m[63:32], d[31:0]}) & MASK;
      end
    end
  endtask

  initial begin
    #(4 * 150000);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    if (!done) begin
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 64; k++) prio_m[k] = 8'h00;
    ctl_m = '0;
    #9 rst_n = 1'b1;
    // R1 reset state
    access(12'h646, 1, 0, 0, 1, 0, 1, "R1 reset lo");
    access(12'h647, 1, 0, 0, 1, 1, 1, "R1 reset hi");
    access(12'h609, 1, 0, 0, 1, 1, 1, "R1 reset ctl");
    // R2 R3 R5 R6 R10 wide write then read
    access(12'h646, 0, 1, 64'h8877_6655_4433_2211, 1, 0, 1, "R10 wr wide");
    access(12'h646, 1, 0, 0, 1, 0, 1, "R2 R5 R6 rd wide");
    access(12'h647, 1, 1, 64'hF0E0_D0C0_B0A0_9080, 1, 0, 1, "R3 wr B");
    access(12'h647, 1, 0, 0, 1, 0, 1, "R3 R10 rd B");
    // R2 narrow accesses, high halves
    access(12'h646, 1, 0, 0, 0, 0, 1, "R2 rd narrow");
    access(12'h656, 1, 1, 64'hDEAD_BEEF_0102_0304, 0, 0, 1, "R3 wr AH narrow");
    access(12'h646, 1, 0, 0, 1, 0, 1, "R3 R6 rd after AH");
    access(12'h657, 1, 1, 64'h1111_1111_5566_7788, 0, 0, 1, "R3 wr BH narrow");
    access(12'h647, 1, 0, 0, 1, 0, 1, "R3 rd after BH");
    // R5 rdz clear via narrow
    access(12'h646, 1, 1, 64'h0000_0000_AABB_CCDD, 0, 0, 1, "R5 wr narrow A");
    access(12'h646, 1, 0, 0, 0, 0, 1, "R5 rd narrow A");
    // R4 misaligned at wide width
    access(12'h656, 1, 1, 64'hFFFF_FFFF_FFFF_FFFF, 1, 0, 1, "R4 misaligned host");
    access(12'h657, 1, 1, 64'hFFFF_FFFF_FFFF_FFFF, 1, 1, 1, "R4 misaligned guest");
    access(12'h646, 1, 0, 0, 1, 0, 1, "R4 no change A");
    access(12'h647, 1, 0, 0, 1, 0, 1, "R4 no change B");
    // R9 feature off
    access(12'h646, 1, 1, 64'h5555_5555_5555_5555, 1, 1, 0, "R9 prio off");
    access(12'h609, 1, 1, 64'hFFFF_FFFF_FFFF_FFFF, 1, 0, 0, "R9 ctl off");
    access(12'h646, 1, 0, 0, 1, 0, 1, "R9 no change");
    access(12'h609, 1, 0, 0, 1, 1, 1, "R9 ctl held");
    // R7 R8 control
    access(12'h609, 0, 1, 64'hFFFF_FFFF_FFFF_FFFF, 1, 0, 1, "R7 wr ctl");
    access(12'h609, 1, 0, 0, 1, 0, 1, "R7 R8 rd host");
    access(12'h609, 1, 0, 0, 0, 1, 1, "R7 R8 rd guest narrow");
    access(12'h609, 1, 1, 64'h1234_5678_0000_0001, 0, 1, 1, "R7 R8 wr narrow");
    access(12'h609, 1, 0, 0, 1, 1, 1, "R7 R8 rd after clear");
    // R11 other address
    access(12'h123, 1, 1, 64'hFFFF_FFFF_FFFF_FFFF, 1, 1, 0, "R11 other");
    access(12'h645, 1, 0, 0, 0, 0, 1, "R11 neighbour");
    // mixed patterns
    for (int n = 0; n < 400; n++) begin
      logic [11:0] a;
      int sel = $urandom_range(0, 6);
      case (sel)
        0: a = 12'h646; 1: a = 12'h656; 2: a = 12'h647; 3: a = 12'h657;
        4: a = 12'h609; default: a = 12'h3A0;
      endcase
      access(a, 1'($urandom), 1'($urandom), {$urandom, $urandom}, 1'($urandom),
             1'($urandom), ($urandom_range(0, 7) != 0), "R2 R4 R6 R7 mix");
    end
    @(negedge clk);
    re = 0; we = 0;
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule